// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a successive-approximation analog-to-digital converter. It recognises a convert command, runs a binary search one bit per clock, and drives a trial word to an external DAC. On each clock it reads back a one-bit comparator decision. While the search runs, a busy flag is high. The finished code is loaded into a result register in the same clock that busy drops.

Two start schemes are provided, chosen by a static mode input. In level-decoded mode, a command is taken when enable is high, select is low and the read/convert line is low. In edge-triggered mode, a high-to-low transition of the read/convert line starts a conversion on its own. When the command is accepted, the length-select line is captured. Low selects a full 12-bit search. High selects a truncated 8-bit search that resolves only the upper eight bits.

Top module: `sar_sequencer`

## Requirements
- R1: With `edge_mode`=0, a conversion is accepted on a rising clock edge where `ce`=1, `cs_n`=0 and `rd_cvt`=0 while idle. If any one of these three conditions is missing, no conversion starts.
- R2: With `len_sel`=0 at acceptance, busy is high for exactly 12 cycles. `result` then equals the largest code C for which the comparator reported input >= C, so every code 0..4095 is reachable.
- R3: With `len_sel`=1 at acceptance, busy is high for exactly 8 cycles. `result[11:4]` holds the search outcome and `result[3:0]` is 0.
- R4: `busy` rises on the edge that accepts a command. It falls on the edge that loads `result`.
- R5: With `edge_mode`=1, a 1-to-0 transition of `rd_cvt` starts a conversion whatever `ce` and `cs_n` are. Holding `rd_cvt` low does not start another one.
- R6: `len_sel` is sampled only at acceptance. Changes during a conversion have no effect on its length or result.
- R7: A convert command that arrives while `busy` is high is dropped. The running conversion keeps its length and result, and no conversion follows it.
- R8: The search is MSB-first. In the first busy cycle `trial` is 12'h800. In every idle cycle `trial` is 0.
- R9: After reset, `busy`=0, `trial`=0 and `result`=0. `result` holds its value whenever idle.
- R10: Offset-binary codes either side of the major carry (12'h7FF and 12'h800) both resolve exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_mode | input | 1 | 0: level-decoded start, 1: falling-edge start on `rd_cvt` |
| ce | input | 1 | Enable, active high |
| cs_n | input | 1 | Select, active low |
| rd_cvt | input | 1 | Read/convert line (low = convert) |
| len_sel | input | 1 | Search length select: 0 full, 1 short |
| cmp_hi | input | 1 | Comparator: 1 when input >= DAC level |
| trial | output | 12 | Trial word to the DAC |
| busy | output | 1 | High while a search runs |
| result | output | 12 | Last finished code |

## Verification
A comparator model that answers `code >= trial` is swept over all 4096 codes in full length. Every fifth code is swept in short length, so a wrong bit index, a bit that is not cleared, or a short search that leaves junk in the low nibble shows up as a wrong code. The bench counts busy cycles on every conversion, which exposes an off-by-one in the stop index. It flips `len_sel` mid-conversion and fires commands during busy, which catch a design that samples the length late or re-arms from a stale command. In edge mode, holding `rd_cvt` low after a conversion catches a level-sensitive start in place of an edge-detected one.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic {
        START_LEVEL = 1'b0,
        START_EDGE  = 1'b1
    } start_mode_e;

    typedef struct packed {
        logic rd_prev;
    } start_state_t;

endpackage

// File: rtl/sar_start_dec.sv
module sar_start_dec
    import sar_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  start_mode_e mode,
    input  logic        ce,
    input  logic        cs_n,
    input  logic        rd_cvt,
    output logic        start_req
);

    start_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.rd_prev = rd_cvt;
        if (mode == START_EDGE) begin
            start_req = st_q.rd_prev && !rd_cvt;
        end else begin
            start_req = ce && !cs_n && !rd_cvt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rd_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sar_trial_engine.sv
module sar_trial_engine #(
    parameter int unsigned W       = 12,
    parameter int unsigned SHORT_W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_req,
    input  logic         len_sel,
    input  logic         cmp_hi,
    output logic [W-1:0] trial,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] done_word
);

    localparam int unsigned IDX_W     = $clog2(W);
    localparam logic [IDX_W-1:0] TOP  = IDX_W'(W - 1);
    localparam logic [IDX_W-1:0] STOP_SHORT = IDX_W'(W - SHORT_W);
    localparam logic [IDX_W-1:0] STOP_FULL  = '0;

    typedef struct packed {
        logic             busy;
        logic             short_cyc;
        logic [IDX_W-1:0] idx;
        logic [W-1:0]     word;
    } eng_state_t;

    eng_state_t st_d, st_q;
    logic [IDX_W-1:0] stop_idx;
    logic [W-1:0]     decided;
    logic [W-1:0]     low_mask;

    // Mask that clears the unresolved bits of a short search.
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_mask
            if (g < W - SHORT_W) begin : g_lo
                assign low_mask[g] = 1'b0;
            end else begin : g_hi
                assign low_mask[g] = 1'b1;
            end
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        stop_idx = st_q.short_cyc ? STOP_SHORT : STOP_FULL;
        decided  = st_q.word;
        decided[st_q.idx] = cmp_hi;
        done      = st_q.busy && (st_q.idx == stop_idx);
        done_word = st_q.short_cyc ? (decided & low_mask) : decided;

        if (st_q.busy) begin
            if (done) begin
                st_d.busy = 1'b0;
                st_d.word = '0;
                st_d.idx  = '0;
            end else begin
                st_d.word = decided;
                st_d.word[st_q.idx - 1'b1] = 1'b1;
                st_d.idx  = st_q.idx - 1'b1;
            end
        end else if (start_req) begin
            st_d.busy      = 1'b1;
            st_d.short_cyc = len_sel;
            st_d.idx       = TOP;
            st_d.word      = '0;
            st_d.word[W-1] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trial = st_q.word;
    assign busy  = st_q.busy;

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (load) begin
            val_d = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign q = val_q;

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int unsigned W       = 12,
    parameter int unsigned SHORT_W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         edge_mode,
    input  logic         ce,
    input  logic         cs_n,
    input  logic         rd_cvt,
    input  logic         len_sel,
    input  logic         cmp_hi,
    output logic [W-1:0] trial,
    output logic         busy,
    output logic [W-1:0] result
);

    logic         start_req;
    logic         done;
    logic [W-1:0] done_word;
    start_mode_e  mode;

    assign mode = edge_mode ? START_EDGE : START_LEVEL;

    sar_start_dec u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .ce        (ce),
        .cs_n      (cs_n),
        .rd_cvt    (rd_cvt),
        .start_req (start_req)
    );

    sar_trial_engine #(.W(W), .SHORT_W(SHORT_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .len_sel   (len_sel),
        .cmp_hi    (cmp_hi),
        .trial     (trial),
        .busy      (busy),
        .done      (done),
        .done_word (done_word)
    );

    sar_result_reg #(.W(W)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (done),
        .din   (done_word),
        .q     (result)
    );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int unsigned W       = 12,
    parameter int unsigned SHORT_W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic [W-1:0] trial,
    input logic [W-1:0] result
);

    localparam int unsigned CNT_W = $clog2(W + 2);
    localparam logic [CNT_W-1:0] LEN_FULL  = CNT_W'(W);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_W);
    localparam logic [W-1:0] FIRST_TRIAL = {1'b1, {(W-1){1'b0}}};

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end else begin
            run_cnt <= '0;
        end
    end

    // R2 R3 R4: a search lasts exactly the full or the short length
    a_r4_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == LEN_FULL || run_cnt == LEN_SHORT));

    // R3: a short search leaves the unresolved low bits at zero
    a_r3_short_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && run_cnt == LEN_SHORT) |-> (result[W-SHORT_W-1:0] == '0));

    // R8: the first trial is the MSB alone
    a_r8_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (trial == FIRST_TRIAL));

    // R8: no trial bits are driven while idle
    a_r8_idle_trial: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (trial == '0));

    // R9: the result holds across idle cycles
    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(result));

endmodule

bind sar_sequencer sar_seq_chk #(.W(W), .SHORT_W(SHORT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .trial  (trial),
    .result (result)
);

// File: tb/tb_sar_sequencer.sv
`timescale 1ns/1ps
module tb_sar_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        edge_mode = 1'b0;
    logic        ce = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_cvt = 1'b1;
    logic        len_sel = 1'b0;
    logic        cmp_hi;
    logic [11:0] trial;
    logic        busy;
    logic [11:0] result;
    logic [11:0] vin = '0;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign cmp_hi = (vin >= trial);

    sar_sequencer dut (
        .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .ce(ce), .cs_n(cs_n),
        .rd_cvt(rd_cvt), .len_sel(len_sel), .cmp_hi(cmp_hi),
        .trial(trial), .busy(busy), .result(result)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // counts busy cycles starting from the current negedge
    task automatic wait_idle(output int n);
        n = 0;
        while (busy === 1'b1 && n < 40) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_fc(input bit shrt);
        @(negedge clk);
        ce = 1'b1; cs_n = 1'b0; rd_cvt = 1'b0; len_sel = shrt;
        @(negedge clk);
        ce = 1'b0; cs_n = 1'b1; rd_cvt = 1'b1;
    endtask

    task automatic conv_fc(input logic [11:0] code, input bit shrt, input bit full_checks);
        int n;
        logic [11:0] exp;
        vin = code;
        pulse_fc(shrt);
        if (full_checks) begin
            chk(busy === 1'b1, "R4 busy rises on accept", int'(busy), 1);
            chk(trial === 12'h800, "R8 first trial", int'(trial), 'h800);
        end
        wait_idle(n);
        exp = shrt ? (code & 12'hFF0) : code;
        if (full_checks) begin
            chk(n == (shrt ? 8 : 12), shrt ? "R3 short length" : "R2 full length", n, shrt ? 8 : 12);
            chk(trial === 12'h0, "R8 idle trial", int'(trial), 0);
        end
        chk(result === exp, shrt ? "R3 short result" : "R2 full result", int'(result), int'(exp));
    endtask

    initial begin
        #1_900_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [11:0] keep;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R9 reset busy", int'(busy), 0);
        chk(trial === 12'h0, "R9 reset trial", int'(trial), 0);
        chk(result === 12'h0, "R9 reset result", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: each missing start condition blocks the start
        vin = 12'h555;
        ce = 1'b0; cs_n = 1'b0; rd_cvt = 1'b0; @(negedge clk);
        chk(busy === 1'b0, "R1 no start without ce", int'(busy), 0);
        ce = 1'b1; cs_n = 1'b1; rd_cvt = 1'b0; @(negedge clk);
        chk(busy === 1'b0, "R1 no start without cs_n low", int'(busy), 0);
        ce = 1'b1; cs_n = 1'b0; rd_cvt = 1'b1; @(negedge clk);
        chk(busy === 1'b0, "R1 no start with rd_cvt high", int'(busy), 0);
        ce = 1'b0; cs_n = 1'b1; rd_cvt = 1'b1;
        chk(result === 12'h0, "R9 result held after non-starts", int'(result), 0);

        // R10: major carry neighbours
        conv_fc(12'h7FF, 1'b0, 1'b1);
        conv_fc(12'h800, 1'b0, 1'b1);

        // R2: exhaustive full-length sweep
        for (int c = 0; c < 4096; c++) conv_fc(12'(c), 1'b0, (c % 512) == 0);

        // R3: short-length sweep
        for (int c = 0; c < 4096; c += 5) conv_fc(12'(c), 1'b1, (c % 640) == 0);
        conv_fc(12'hFFF, 1'b1, 1'b1);

        // R9: result holds while idle
        keep = result;
        vin = 12'h123;
        repeat (5) @(negedge clk);
        chk(result === keep, "R9 result hold", int'(result), int'(keep));

        // R6: len_sel changes mid-conversion are ignored
        vin = 12'hABC;
        pulse_fc(1'b1);
        len_sel = 1'b0;
        wait_idle(n);
        chk(n == 8, "R6 short length kept", n, 8);
        chk(result === 12'hAB0, "R6 short result kept", int'(result), 'hAB0);
        vin = 12'h3C7;
        pulse_fc(1'b0);
        len_sel = 1'b1;
        wait_idle(n);
        chk(n == 12, "R6 full length kept", n, 12);
        chk(result === 12'h3C7, "R6 full result kept", int'(result), 'h3C7);

        // R7: command while busy is dropped
        vin = 12'h96A;
        pulse_fc(1'b0);
        repeat (3) @(negedge clk);
        vin = 12'h96A;
        ce = 1'b1; cs_n = 1'b0; rd_cvt = 1'b0; len_sel = 1'b1;
        @(negedge clk);
        ce = 1'b0; cs_n = 1'b1; rd_cvt = 1'b1;
        wait_idle(n);
        chk(n == 8, "R7 running length unchanged", n + 4, 12);
        chk(result === 12'h96A, "R7 running result unchanged", int'(result), 'h96A);
        @(negedge clk);
        chk(busy === 1'b0, "R7 no follow-on conversion", int'(busy), 0);

        // R5: edge-triggered start, ce/cs ignored, low level does not restart
        edge_mode = 1'b1;
        ce = 1'b0; cs_n = 1'b1; rd_cvt = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy === 1'b0, "R5 no start on high level", int'(busy), 0);
        vin = 12'h4D2; len_sel = 1'b0;
        rd_cvt = 1'b0;
        @(negedge clk);
        chk(busy === 1'b1, "R5 start on falling edge", int'(busy), 1);
        wait_idle(n);
        chk(n == 12, "R5 edge full length", n, 12);
        chk(result === 12'h4D2, "R5 edge full result", int'(result), 'h4D2);
        repeat (4) @(negedge clk);
        chk(busy === 1'b0, "R5 held low does not restart", int'(busy), 0);
        rd_cvt = 1'b1; @(negedge clk);
        vin = 12'h0F9; len_sel = 1'b1; rd_cvt = 1'b0;
        @(negedge clk);
        len_sel = 1'b0;
        wait_idle(n);
        chk(n == 8, "R5 edge short length", n, 8);
        chk(result === 12'h0F0, "R5 edge short result", int'(result), 'h0F0);
        rd_cvt = 1'b1;
        repeat (2) @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule